// File: doc/BRIEF.md
# Single-Level Page Translation Walker

The walker sits between a CPU-side request port and a word-wide memory bus. For every data request it translates a 32-bit byte-granular linear address through a one-level page table kept in memory. The upper twenty address bits select a table entry. The lower twelve bits are a byte offset inside a 4 KB page. The walker reads the entry, checks that it is marked present, joins the entry's frame number with the offset, and then performs the requested 32-bit read or write at that physical location. No translation is cached, so every successful request costs one table read followed by one data access.

Two configuration registers are set through a small write port. One holds the physical location of the table and the other holds the number of valid entries in it. Both can be written only while the walker is idle. The memory bus carries only byte address bits 31 to 2, and every transfer moves a whole 32-bit row. A transfer may be stretched by any number of wait cycles.

Top module: `pgwalk_top`

## Requirements
- R1: After reset `req_ready` is 1, and `rsp_valid` and `mem_req` are 0. The table size register is 0, so every request made before configuration ends in a fault.
- R2: The table read is issued on word address `table_base[31:2] + page_index`, where `page_index` is linear address bits 31..12. In byte terms this is the base plus four times the index.
- R3: The data access is issued on word address `{entry[31:12], linear[11:2]}`. Linear address bits 1..0 never reach the bus, and every transfer is a full 32-bit word.
- R4: A request whose page index is greater than or equal to the table size gets `rsp_fault`=1 with no bus cycle at all. Its response appears one cycle after the request is accepted.
- R5: If the fetched entry has bit 0 (present) equal to 0, the request gets `rsp_fault`=1 after exactly one bus cycle, the table read. Its response appears two cycles after that read is acknowledged.
- R6: A request that translates makes exactly two bus cycles: the table read with `mem_we`=0, then the data access with `mem_we` equal to `req_write`. The response appears one cycle after the data access is acknowledged, with `rsp_fault`=0. `rsp_rdata` holds the word read for a read, and 0 for a write or a fault.
- R7: Only one request is handled at a time. `req_ready` is high only in the idle state, and stays low from the accepting edge through the response cycle.
- R8: The configuration port writes the table base when `cfg_sel`=0 and the table size when `cfg_sel`=1. The size register is 21 bits wide, so up to 2^20 entries are allowed, and base bits 1..0 are dropped. A configuration write made while a request is in progress is ignored.
- R9: While `mem_req` is high and `mem_ack` is low, `mem_addr`, `mem_we` and `mem_wdata` stay unchanged, for any number of wait cycles.
- R10: `rsp_valid` is a single-cycle pulse, one for each accepted request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Configuration write strobe |
| cfg_sel | input | 1 | 0 selects table base, 1 selects table size |
| cfg_wdata | input | 32 | Configuration write value |
| req_valid | input | 1 | Request offered |
| req_ready | output | 1 | Walker idle and able to accept |
| req_write | input | 1 | 1 for write, 0 for read |
| req_addr | input | 32 | Linear byte address |
| req_wdata | input | 32 | Write data |
| rsp_valid | output | 1 | Response pulse |
| rsp_fault | output | 1 | Translation failed |
| rsp_rdata | output | 32 | Read data |
| mem_req | output | 1 | Bus transfer request |
| mem_we | output | 1 | Bus transfer is a write |
| mem_addr | output | 30 | Bus word address (byte bits 31..2) |
| mem_wdata | output | 32 | Bus write data |
| mem_ack | input | 1 | Bus transfer complete |
| mem_rdata | input | 32 | Bus read data |

## Verification
The response is due at one of three fixed points: one cycle after acceptance for a range fault, two cycles after the table-read acknowledge for an absent entry, and one cycle after the data acknowledge for a translated access. For each request the driver records which of these anchors applies. The bus model time-stamps every acknowledge, and the monitor compares the cycle in which `rsp_valid` is seen against that anchor. The same monitor also checks the logged bus transfers (count, word addresses and direction) and the response fields. The bus model checks, across wait cycles of 0 to 6, that nothing on the bus moves before the acknowledge.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;

    typedef enum logic [2:0] {
        ST_IDLE    = 3'd0,
        ST_FETCH   = 3'd1,
        ST_CHECK   = 3'd2,
        ST_DATA    = 3'd3,
        ST_RESPOND = 3'd4
    } walk_state_e;

    localparam logic CFG_SEL_BASE  = 1'b0;
    localparam logic CFG_SEL_LIMIT = 1'b1;

endpackage

// File: rtl/pgwalk_cfg.sv
module pgwalk_cfg #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = AW - OFF_W,
    localparam int LIM_W = IDX_W + 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             idle,
    input  logic             cfg_we,
    input  logic             cfg_sel,
    input  logic [AW-1:0]    cfg_wdata,
    output logic [AW-3:0]    base_word,
    output logic [LIM_W-1:0] limit
);
    import pgwalk_pkg::*;

    typedef struct packed {
        logic [AW-3:0]    base;
        logic [LIM_W-1:0] limit;
    } cfg_t;

    cfg_t cfg_d, cfg_q;

    always_comb begin
        cfg_d = cfg_q;
        if (cfg_we && idle) begin
            if (cfg_sel == CFG_SEL_BASE) begin
                cfg_d.base = cfg_wdata[AW-1:2];
            end else begin
                cfg_d.limit = cfg_wdata[LIM_W-1:0];
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cfg_q <= '0;
        end else begin
            cfg_q <= cfg_d;
        end
    end

    assign base_word = cfg_q.base;
    assign limit     = cfg_q.limit;

    logic unused_cfg_low;
    assign unused_cfg_low = ^cfg_wdata[1:0];

    // R8: writes outside idle leave both registers untouched
    a_r8_cfg_ignored_busy: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_we && !idle) |=> ($stable(base_word) && $stable(limit)));

endmodule

// File: rtl/pgwalk_xlate.sv
module pgwalk_xlate #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = AW - OFF_W,
    localparam int LIM_W = IDX_W + 1,
    localparam int WA_W  = AW - 2,
    localparam int OWD_W = OFF_W - 2
) (
    input  logic [WA_W-1:0]  base_word,
    input  logic [LIM_W-1:0] limit,
    input  logic [IDX_W-1:0] chk_idx,
    input  logic [WA_W-1:0]  lin_word,
    input  logic [IDX_W-1:0] frame,
    output logic             out_of_range,
    output logic [WA_W-1:0]  entry_waddr,
    output logic [WA_W-1:0]  data_waddr
);
    logic [IDX_W-1:0] held_idx;
    logic [OWD_W-1:0] held_off;

    always_comb begin
        held_idx     = lin_word[WA_W-1:OWD_W];
        held_off     = lin_word[OWD_W-1:0];
        out_of_range = ({1'b0, chk_idx} >= limit);
        entry_waddr  = base_word + {{(WA_W-IDX_W){1'b0}}, held_idx};
        data_waddr   = {frame, held_off};
    end

endmodule

// File: rtl/pgwalk_fsm.sv
module pgwalk_fsm #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = AW - OFF_W,
    localparam int WA_W  = AW - 2
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             req_valid,
    input  logic             req_write,
    input  logic [WA_W-1:0]  req_word,
    input  logic [AW-1:0]    req_wdata,
    input  logic             out_of_range,
    input  logic [WA_W-1:0]  entry_waddr,
    input  logic [WA_W-1:0]  data_waddr,
    output logic             idle,
    output logic             req_ready,
    output logic             rsp_valid,
    output logic             rsp_fault,
    output logic [AW-1:0]    rsp_rdata,
    output logic             mem_req,
    output logic             mem_we,
    output logic [WA_W-1:0]  mem_addr,
    output logic [AW-1:0]    mem_wdata,
    input  logic             mem_ack,
    input  logic [AW-1:0]    mem_rdata,
    output logic [WA_W-1:0]  lin_word,
    output logic [IDX_W-1:0] frame
);
    import pgwalk_pkg::*;

    typedef struct packed {
        walk_state_e      st;
        logic [WA_W-1:0]  lin;
        logic             wr;
        logic [AW-1:0]    wdata;
        logic [IDX_W-1:0] frame;
        logic             present;
        logic [AW-1:0]    rdata;
        logic             fault;
    } walk_t;

    walk_t w_d, w_q;

    always_comb begin
        w_d = w_q;
        case (w_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    w_d.lin     = req_word;
                    w_d.wr      = req_write;
                    w_d.wdata   = req_wdata;
                    w_d.rdata   = '0;
                    w_d.present = 1'b0;
                    w_d.fault   = out_of_range;
                    w_d.st      = out_of_range ? ST_RESPOND : ST_FETCH;
                end
            end
            ST_FETCH: begin
                if (mem_ack) begin
                    w_d.frame   = mem_rdata[AW-1:OFF_W];
                    w_d.present = mem_rdata[0];
                    w_d.st      = ST_CHECK;
                end
            end
            ST_CHECK: begin
                if (w_q.present) begin
                    w_d.st = ST_DATA;
                end else begin
                    w_d.fault = 1'b1;
                    w_d.st    = ST_RESPOND;
                end
            end
            ST_DATA: begin
                if (mem_ack) begin
                    if (!w_q.wr) begin
                        w_d.rdata = mem_rdata;
                    end
                    w_d.st = ST_RESPOND;
                end
            end
            ST_RESPOND: begin
                w_d.st = ST_IDLE;
            end
            default: begin
                w_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            w_q    <= '0;
            w_q.st <= ST_IDLE;
        end else begin
            w_q <= w_d;
        end
    end

    assign idle      = (w_q.st == ST_IDLE);
    assign req_ready = idle;
    assign rsp_valid = (w_q.st == ST_RESPOND);
    assign rsp_fault = w_q.fault;
    assign rsp_rdata = w_q.rdata;
    assign mem_req   = (w_q.st == ST_FETCH) || (w_q.st == ST_DATA);
    assign mem_we    = (w_q.st == ST_DATA) && w_q.wr;
    assign mem_addr  = (w_q.st == ST_DATA) ? data_waddr : entry_waddr;
    assign mem_wdata = w_q.wdata;
    assign lin_word  = w_q.lin;
    assign frame     = w_q.frame;

    // R9: bus outputs frozen while a transfer waits
    a_r9_bus_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req && !mem_ack) |=> (mem_req && $stable(mem_addr)
                                   && $stable(mem_we) && $stable(mem_wdata)));

    // R7: accepting only when nothing is in flight
    a_r7_ready_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (!mem_req && !rsp_valid));

    // R7: ready drops right after an accept
    a_r7_ready_drops: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R10: response is a single-cycle pulse
    a_r10_rsp_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    // R4: out-of-range request answers next cycle with a fault
    a_r4_range_fault: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready && out_of_range) |=> (rsp_valid && rsp_fault && !mem_req));

    // R6: a bus write is only ever the data access
    a_r6_write_is_data: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> (mem_req && $past(!mem_req)) || (mem_req && $past(mem_we)));

endmodule

// File: rtl/pgwalk_top.sv
module pgwalk_top #(
    parameter int AW    = 32,
    parameter int OFF_W = 12,
    localparam int IDX_W = AW - OFF_W,
    localparam int LIM_W = IDX_W + 1,
    localparam int WA_W  = AW - 2
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            cfg_we,
    input  logic            cfg_sel,
    input  logic [AW-1:0]   cfg_wdata,
    input  logic            req_valid,
    output logic            req_ready,
    input  logic            req_write,
    input  logic [AW-1:0]   req_addr,
    input  logic [AW-1:0]   req_wdata,
    output logic            rsp_valid,
    output logic            rsp_fault,
    output logic [AW-1:0]   rsp_rdata,
    output logic            mem_req,
    output logic            mem_we,
    output logic [WA_W-1:0] mem_addr,
    output logic [AW-1:0]   mem_wdata,
    input  logic            mem_ack,
    input  logic [AW-1:0]   mem_rdata
);
    logic             idle;
    logic [WA_W-1:0]  base_word;
    logic [LIM_W-1:0] limit;
    logic             out_of_range;
    logic [WA_W-1:0]  entry_waddr;
    logic [WA_W-1:0]  data_waddr;
    logic [WA_W-1:0]  lin_word;
    logic [IDX_W-1:0] frame;

    logic unused_req_low;
    assign unused_req_low = ^req_addr[1:0];

    pgwalk_cfg #(.AW(AW), .OFF_W(OFF_W)) u_cfg (
        .clk       (clk),
        .rst_n     (rst_n),
        .idle      (idle),
        .cfg_we    (cfg_we),
        .cfg_sel   (cfg_sel),
        .cfg_wdata (cfg_wdata),
        .base_word (base_word),
        .limit     (limit)
    );

    pgwalk_xlate #(.AW(AW), .OFF_W(OFF_W)) u_xlate (
        .base_word    (base_word),
        .limit        (limit),
        .chk_idx      (req_addr[AW-1:OFF_W]),
        .lin_word     (lin_word),
        .frame        (frame),
        .out_of_range (out_of_range),
        .entry_waddr  (entry_waddr),
        .data_waddr   (data_waddr)
    );

    pgwalk_fsm #(.AW(AW), .OFF_W(OFF_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_write    (req_write),
        .req_word     (req_addr[AW-1:2]),
        .req_wdata    (req_wdata),
        .out_of_range (out_of_range),
        .entry_waddr  (entry_waddr),
        .data_waddr   (data_waddr),
        .idle         (idle),
        .req_ready    (req_ready),
        .rsp_valid    (rsp_valid),
        .rsp_fault    (rsp_fault),
        .rsp_rdata    (rsp_rdata),
        .mem_req      (mem_req),
        .mem_we       (mem_we),
        .mem_addr     (mem_addr),
        .mem_wdata    (mem_wdata),
        .mem_ack      (mem_ack),
        .mem_rdata    (mem_rdata),
        .lin_word     (lin_word),
        .frame        (frame)
    );

endmodule

// File: tb/pgwalk_top_bench.sv
`timescale 1ns/1ps
module pgwalk_top_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_we = 1'b0;
    logic        cfg_sel = 1'b0;
    logic [31:0] cfg_wdata = '0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_write = 1'b0;
    logic [31:0] req_addr = '0;
    logic [31:0] req_wdata = '0;
    logic        rsp_valid;
    logic        rsp_fault;
    logic [31:0] rsp_rdata;
    logic        mem_req;
    logic        mem_we;
    logic [29:0] mem_addr;
    logic [31:0] mem_wdata;
    logic        mem_ack;
    logic [31:0] mem_rdata;

    always #4 clk = ~clk;

    pgwalk_top u_pgwalk_top (
        .clk(clk), .rst_n(rst_n),
        .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_wdata(cfg_wdata),
        .req_valid(req_valid), .req_ready(req_ready), .req_write(req_write),
        .req_addr(req_addr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_fault(rsp_fault), .rsp_rdata(rsp_rdata),
        .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
        .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata)
    );

    int n_cmp = 0;
    int n_bad = 0;
    int cyc = 0;
    int last_ack = 0;
    int wait_n = 0;
    bit done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    typedef struct {
        bit          fault;
        logic [31:0] rdata;
        int          nbus;
        logic [29:0] a0;
        logic [29:0] a1;
        bit          we1;
        int          kind;
        int          acc;
        string       tag;
    } exp_t;

    exp_t       exp_q[$];
    logic [30:0] bus_log[$];
    logic [31:0] mem [logic [29:0]];

    logic [31:0] base_m = '0;
    logic [20:0] lim_m = '0;

    task automatic chk(input bit ok, input string tag, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
        end
    endtask

    function automatic logic [31:0] rd(input logic [29:0] a);
        return mem.exists(a) ? mem[a] : 32'h0;
    endfunction

    // bus model: acknowledges after wait_n wait cycles, checks holding
    initial begin
        logic [29:0] a0;
        logic        w0;
        logic [31:0] d0;
        int          wc;
        wc = 0; a0 = '0; w0 = 1'b0; d0 = '0;
        mem_ack = 1'b0;
        mem_rdata = '0;
        forever begin
            @(negedge clk);
            if (mem_ack) begin
                mem_ack = 1'b0;
            end else if (mem_req && rst_n) begin
                if (wc == 0) begin
                    a0 = mem_addr; w0 = mem_we; d0 = mem_wdata;
                end
                if (wc >= wait_n) begin
                    if (wc > 0) begin
                        chk(mem_addr == a0 && mem_we == w0 && mem_wdata == d0,
                            "R9", "bus held over waits", {2'b0, mem_addr}, {2'b0, a0});
                    end
                    if (mem_we) mem[mem_addr] = mem_wdata;
                    mem_rdata = rd(mem_addr);
                    mem_ack = 1'b1;
                    bus_log.push_back({mem_we, mem_addr});
                    last_ack = cyc;
                    wc = 0;
                end else begin
                    wc++;
                end
            end
        end
    end

    // monitor: pops the scoreboard on each response
    initial begin
        forever begin
            @(negedge clk);
            if (rsp_valid && rst_n) begin
                if (exp_q.size() == 0) begin
                    chk(1'b0, "R10", "unexpected response", 32'h1, 32'h0);
                end else begin
                    exp_t e;
                    int   due;
                    e = exp_q.pop_front();
                    due = (e.kind == 0) ? e.acc + 1 :
                          (e.kind == 1) ? last_ack + 1 : last_ack + 2;
                    chk(rsp_fault == e.fault, e.tag, "fault", {31'b0, rsp_fault}, {31'b0, e.fault});
                    chk(rsp_rdata == e.rdata, e.tag, "rdata", rsp_rdata, e.rdata);
                    chk(cyc == due, e.tag, "response cycle", cyc, due);
                    chk(req_ready == 1'b0, "R7", "ready low in response", {31'b0, req_ready}, 32'h0);
                    chk(bus_log.size() == e.nbus, e.tag, "bus cycles", bus_log.size(), e.nbus);
                    if (bus_log.size() == e.nbus && e.nbus >= 1) begin
                        chk(bus_log[0] == {1'b0, e.a0}, "R2", "table read address",
                            {1'b0, bus_log[0]}, {2'b0, e.a0});
                    end
                    if (bus_log.size() == e.nbus && e.nbus == 2) begin
                        chk(bus_log[1] == {e.we1, e.a1}, "R3", "data access address",
                            {1'b0, bus_log[1]}, {1'b0, e.we1, e.a1});
                    end
                    bus_log.delete();
                end
            end
        end
    end

    task automatic cfg_write(input bit sel, input logic [31:0] v, input bit track);
        @(negedge clk);
        cfg_we = 1'b1; cfg_sel = sel; cfg_wdata = v;
        @(negedge clk);
        cfg_we = 1'b0;
        if (track) begin
            if (sel) lim_m = v[20:0];
            else     base_m = {v[31:2], 2'b00};
        end
    endtask

    task automatic send(input bit wr, input logic [31:0] la, input logic [31:0] wd,
                        input string tag);
        exp_t        e;
        logic [19:0] idx;
        logic [31:0] pte;
        idx = la[31:12];
        e.tag = tag; e.rdata = '0; e.a0 = '0; e.a1 = '0; e.we1 = wr;
        if ({1'b0, idx} >= lim_m) begin
            e.fault = 1'b1; e.nbus = 0; e.kind = 0;
        end else begin
            e.a0 = base_m[31:2] + {10'b0, idx};
            pte = rd(e.a0);
            if (!pte[0]) begin
                e.fault = 1'b1; e.nbus = 1; e.kind = 2;
            end else begin
                e.fault = 1'b0; e.nbus = 2; e.kind = 1;
                e.a1 = {pte[31:12], la[11:2]};
                if (!wr) e.rdata = rd(e.a1);
            end
        end
        @(negedge clk);
        req_valid = 1'b1; req_write = wr; req_addr = la; req_wdata = wd;
        e.acc = cyc;
        exp_q.push_back(e);
        @(negedge clk);
        req_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            n_bad++;
            n_cmp++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        // table at 0x0001_0000, frames 0x40, 0x55, 0x99
        mem[30'h0000_4000] = 32'h0004_0001;  // idx0 present
        mem[30'h0000_4001] = 32'h0005_5001;  // idx1 present
        mem[30'h0000_4002] = 32'h0007_7000;  // idx2 absent
        mem[30'h0000_4003] = 32'h0004_0001;  // idx3 aliases idx0
        mem[30'h0000_4000 + 30'hF_FFFF] = 32'h0009_9001;
        mem[30'h0001_57FF] = 32'h1234_5678;  // phys 0x55FFC
        mem[30'h0002_6404] = 32'hCAFE_F00D;  // phys 0x99010

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset values at the ports
        chk(req_ready == 1'b1, "R1", "ready after reset", {31'b0, req_ready}, 32'h1);
        chk(rsp_valid == 1'b0, "R1", "rsp_valid after reset", {31'b0, rsp_valid}, 32'h0);
        chk(mem_req == 1'b0, "R1", "mem_req after reset", {31'b0, mem_req}, 32'h0);
        send(1'b0, 32'h0000_0124, '0, "R1");

        cfg_write(1'b0, 32'h0001_0003, 1'b1);   // base, low bits dropped (R8)
        cfg_write(1'b1, 32'h0000_0008, 1'b1);   // size 8

        send(1'b1, 32'h0000_0124, 32'hA5A5_0001, "R6");
        send(1'b0, 32'h0000_3124, '0, "R3");
        send(1'b0, 32'h0000_3126, '0, "R3");
        send(1'b0, 32'h0000_1FFC, '0, "R6");
        send(1'b0, 32'h0000_2000, '0, "R5");
        send(1'b0, 32'h0000_7000, '0, "R5");
        send(1'b0, 32'h0000_8000, '0, "R4");
        send(1'b1, 32'h0000_9000, 32'h1, "R4");

        for (int w = 1; w <= 6; w++) begin
            wait_n = w;
            send(w[0], 32'h0000_1004 + 32'(w * 4), 32'h5000_0000 + 32'(w), "R9");
            send(1'b0, 32'h0000_1004 + 32'(w * 4), '0, "R9");
        end

        // R8: config writes during a walk are ignored
        wait_n = 6;
        fork
            send(1'b0, 32'h0000_1FFC, '0, "R8");
            begin
                repeat (3) @(negedge clk);
                cfg_write(1'b1, 32'h0, 1'b0);
                cfg_write(1'b0, 32'h0800_0000, 1'b0);
            end
        join
        wait_n = 0;
        send(1'b0, 32'h0000_1FFC, '0, "R8");

        // R8: 21-bit size reaches the top page index
        cfg_write(1'b1, 32'h0010_0000, 1'b1);
        send(1'b0, 32'hFFFF_F010, '0, "R2");
        send(1'b1, 32'hFFFF_F014, 32'hBEEF_0002, "R6");
        send(1'b0, 32'hFFFF_F014, '0, "R6");

        repeat (4) @(negedge clk);
        // R10: no stray pulses left
        chk(exp_q.size() == 0, "R10", "scoreboard drained", exp_q.size(), 32'h0);
        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

endmodule